// File: doc/BRIEF.md
# Operand Bypass and Load-Use Hazard Unit

This unit chooses, for every consumer of a register value in a five-stage in-order integer pipeline, where that value should come from. It compares the source register indices of the instruction in execute, the store-data source of the instruction in the memory stage, and the register-file read addresses of decode against the destination index, write enable and valid bit of the older instructions in the memory and write-back stages. Its outputs are select codes that drive multiplexers outside the block. The ALU, the register storage and branch resolution sit elsewhere.

Producers whose valid bit is clear never feed a bypass. This covers flushed slots and bubbles. Destination x0 is never bypassed, and a read of x0 is always steered to a constant zero. When a load in the memory stage has not yet returned data that the execute instruction needs, the unit requests a stall. The surrounding pipeline then holds the front stages for one cycle and inserts a bubble behind the consumer. While the whole pipeline is held by an outside stall, the execute and memory-stage selects stay fixed at the values of the last cycle that advanced.

Top module: `fwd_hazard_unit`

## Requirements
- R1: An execute operand whose source index is nonzero and equals the destination of a valid, writing memory-stage producer gets select code 1 (from memory stage), provided the execute instruction is valid.
- R2: An execute operand matching only a valid, writing write-back producer (nonzero destination) gets select code 2 (from write-back); with no match the code is 0 (register file).
- R3: When both the memory-stage and the write-back producers match the same execute operand, code 1 (the younger, memory-stage result) wins.
- R4: The store-data bypass output is 1 when the memory-stage instruction is valid and its store source is nonzero and equals the destination of a valid, writing write-back producer; otherwise it is 0.
- R5: A register-file read address that is nonzero and equals the destination of a valid, writing write-back producer gets read select code 1 (write-back data, same-cycle transparency); an unmatched nonzero address gets code 0 (array).
- R6: A register-file read of address 0 gets read select code 2 (constant zero) whatever the write-back stage holds, and a source or destination index of 0 never produces execute select 1 or 2 nor a store bypass.
- R7: A producer whose valid bit or write enable is clear is never bypassed from, in any stage or for any consumer.
- R8: An invalid execute instruction gets code 0 on both operands and raises no stall; an invalid memory-stage instruction gets store bypass 0.
- R9: The stall request is 1 exactly when the execute instruction is valid, the memory-stage producer is a valid, writing load with a nonzero destination, that destination equals either execute source, and the outside hold is low.
- R10: While the outside hold input is 1, the execute selects and the store bypass equal the values they had in the last cycle with the hold at 0, and the stall request is 0.
- R11: Synchronous active-low reset clears the held selects, so a hold asserted straight out of reset presents code 0 and store bypass 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_hold_i | input | 1 | Whole-pipeline hold from outside (freezes selects) |
| ex_valid_i | input | 1 | Execute-stage instruction valid |
| ex_src_i | input | NUM_EX_SRC x REG_ADDR_W | Execute source indices (0 when unused) |
| mem_valid_i | input | 1 | Memory-stage instruction valid |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| mem_rd_i | input | REG_ADDR_W | Memory-stage destination index |
| mem_store_src_i | input | REG_ADDR_W | Memory-stage store-data source index (0 when unused) |
| wb_valid_i | input | 1 | Write-back instruction valid |
| wb_we_i | input | 1 | Write-back instruction writes a register |
| wb_rd_i | input | REG_ADDR_W | Write-back destination index |
| rd_addr_i | input | NUM_RD_PORTS x REG_ADDR_W | Decode register-file read addresses |
| ex_opd_sel_o | output | NUM_EX_SRC x 2 | Execute operand select: 0 file, 1 memory stage, 2 write-back |
| mem_store_fwd_o | output | 1 | Take store data from write-back |
| rd_sel_o | output | NUM_RD_PORTS x 2 | Read select: 0 array, 1 write-back data, 2 zero |
| load_stall_o | output | 1 | Load-use stall request |

## Verification
The bench sweeps every combination of execute sources and producer destinations in a three-bit register space. It does this twice: once with all producers valid and writing, and once with valid, write and load flags scrambled. The double match is where a design that gave write-back priority would hand stale data to the ALU. The x0 cases catch a design that bypasses a zero destination and so corrupts operands that ought to read zero. The scrambled flags expose bypassing from flushed or non-writing slots and stalls raised for non-loads. Directed sequences hold the pipeline for several cycles while the inputs change under it. A design that re-decides during the hold would latch operands from a stage that never moved, and a hold asserted out of reset would expose a select that was not cleared.

// File: rtl/fwd_pkg.sv
// Package: shared select encodings for the bypass and hazard unit.
// Assumes two-bit select buses on the datapath multiplexers.
package fwd_pkg;

    // Source of an execute-stage operand.
    typedef enum logic [1:0] {
        OPD_REGFILE  = 2'd0,
        OPD_FROM_MEM = 2'd1,
        OPD_FROM_WB  = 2'd2
    } opd_sel_e;

    // Source of a decode-stage register-file read.
    typedef enum logic [1:0] {
        RD_ARRAY   = 2'd0,
        RD_WB_DATA = 2'd1,
        RD_ZERO    = 2'd2
    } rd_sel_e;

endpackage

// File: rtl/fwd_producer_match.sv
// Module: compares one producer slot against a set of consumer indices.
// A hit needs a valid, writing producer with a nonzero destination equal to
// the consumer index. Assumes index 0 is the hard-wired zero register.
module fwd_producer_match #(
    parameter int REG_ADDR_W = 5,
    parameter int NUM_SRC    = 2
) (
    input  logic                                 prod_valid_i,
    input  logic                                 prod_we_i,
    input  logic [REG_ADDR_W-1:0]                prod_rd_i,
    input  logic [NUM_SRC-1:0][REG_ADDR_W-1:0]   src_i,
    output logic [NUM_SRC-1:0]                   hit_o
);

    logic prod_live;

    // Purpose: decide once whether the producer may feed anyone at all.
    always_comb begin
        prod_live = prod_valid_i && prod_we_i && (prod_rd_i != '0);
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_cmp
        // Purpose: per-consumer index comparison.
        always_comb begin
            hit_o[k] = prod_live && (src_i[k] == prod_rd_i);
        end
    end

endmodule

// File: rtl/fwd_operand_select.sv
// Module: turns memory-stage and write-back hits into operand select codes.
// The memory stage holds the younger result and therefore takes priority.
// Assumes hits already exclude x0 and dead producers.
module fwd_operand_select #(
    parameter int NUM_SRC = 2
) (
    input  logic                     consumer_valid_i,
    input  logic [NUM_SRC-1:0]       mem_hit_i,
    input  logic [NUM_SRC-1:0]       wb_hit_i,
    output logic [NUM_SRC-1:0][1:0]  sel_o
);
    import fwd_pkg::*;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_opd
        opd_sel_e pick;
        // Purpose: priority pick for one operand, youngest producer first.
        always_comb begin
            if (!consumer_valid_i)  pick = OPD_REGFILE;
            else if (mem_hit_i[k])  pick = OPD_FROM_MEM;
            else if (wb_hit_i[k])   pick = OPD_FROM_WB;
            else                    pick = OPD_REGFILE;
            sel_o[k] = pick;
        end
    end

endmodule

// File: rtl/fwd_read_bypass.sv
// Module: register-file read steering for decode. A read of x0 goes to a
// constant zero; a read that meets the same-cycle write-back goes to the
// write data; anything else reads the array.
module fwd_read_bypass #(
    parameter int REG_ADDR_W = 5,
    parameter int NUM_PORTS  = 2
) (
    input  logic [NUM_PORTS-1:0][REG_ADDR_W-1:0]  addr_i,
    input  logic [NUM_PORTS-1:0]                  wb_hit_i,
    output logic [NUM_PORTS-1:0][1:0]             sel_o
);
    import fwd_pkg::*;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rd_sel_e pick;
        // Purpose: choose zero, write-back data or the array for one port.
        always_comb begin
            if (addr_i[p] == '0)  pick = RD_ZERO;
            else if (wb_hit_i[p]) pick = RD_WB_DATA;
            else                  pick = RD_ARRAY;
            sel_o[p] = pick;
        end
    end

endmodule

// File: rtl/fwd_hazard_unit.sv
// Module: top of the bypass and load-use hazard unit. Produces execute
// operand selects, a write-back to memory-stage store bypass, register-file
// transparency selects and a load-use stall request. Execute and store
// selects are held in a register while the outside hold is asserted.
// Assumes: unused sources carry index 0; datapath muxes are external.
module fwd_hazard_unit #(
    parameter int REG_ADDR_W   = 5,
    parameter int NUM_EX_SRC   = 2,
    parameter int NUM_RD_PORTS = 2
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     pipe_hold_i,
    input  logic                                     ex_valid_i,
    input  logic [NUM_EX_SRC-1:0][REG_ADDR_W-1:0]    ex_src_i,
    input  logic                                     mem_valid_i,
    input  logic                                     mem_we_i,
    input  logic                                     mem_load_i,
    input  logic [REG_ADDR_W-1:0]                    mem_rd_i,
    input  logic [REG_ADDR_W-1:0]                    mem_store_src_i,
    input  logic                                     wb_valid_i,
    input  logic                                     wb_we_i,
    input  logic [REG_ADDR_W-1:0]                    wb_rd_i,
    input  logic [NUM_RD_PORTS-1:0][REG_ADDR_W-1:0]  rd_addr_i,
    output logic [NUM_EX_SRC-1:0][1:0]               ex_opd_sel_o,
    output logic                                     mem_store_fwd_o,
    output logic [NUM_RD_PORTS-1:0][1:0]             rd_sel_o,
    output logic                                     load_stall_o
);
    import fwd_pkg::*;

    localparam int SEL_BITS = 2 * NUM_EX_SRC;

    logic [NUM_EX_SRC-1:0]        ex_mem_hit;
    logic [NUM_EX_SRC-1:0]        ex_wb_hit;
    logic [0:0]                   st_wb_hit;
    logic [NUM_RD_PORTS-1:0]      rd_wb_hit;
    logic [NUM_EX_SRC-1:0][1:0]   live_sel;
    logic                         live_store;
    logic [SEL_BITS-1:0]          held_sel;
    logic                         held_store;
    logic                         load_hazard;

    // Memory-stage producer against execute sources.
    fwd_producer_match #(.REG_ADDR_W(REG_ADDR_W), .NUM_SRC(NUM_EX_SRC)) i_mem_vs_ex (
        .prod_valid_i (mem_valid_i),
        .prod_we_i    (mem_we_i),
        .prod_rd_i    (mem_rd_i),
        .src_i        (ex_src_i),
        .hit_o        (ex_mem_hit)
    );

    // Write-back producer against execute sources.
    fwd_producer_match #(.REG_ADDR_W(REG_ADDR_W), .NUM_SRC(NUM_EX_SRC)) i_wb_vs_ex (
        .prod_valid_i (wb_valid_i),
        .prod_we_i    (wb_we_i),
        .prod_rd_i    (wb_rd_i),
        .src_i        (ex_src_i),
        .hit_o        (ex_wb_hit)
    );

    // Write-back producer against the memory-stage store-data source.
    fwd_producer_match #(.REG_ADDR_W(REG_ADDR_W), .NUM_SRC(1)) i_wb_vs_store (
        .prod_valid_i (wb_valid_i),
        .prod_we_i    (wb_we_i),
        .prod_rd_i    (wb_rd_i),
        .src_i        (mem_store_src_i),
        .hit_o        (st_wb_hit)
    );

    // Write-back producer against decode read addresses.
    fwd_producer_match #(.REG_ADDR_W(REG_ADDR_W), .NUM_SRC(NUM_RD_PORTS)) i_wb_vs_rd (
        .prod_valid_i (wb_valid_i),
        .prod_we_i    (wb_we_i),
        .prod_rd_i    (wb_rd_i),
        .src_i        (rd_addr_i),
        .hit_o        (rd_wb_hit)
    );

    fwd_operand_select #(.NUM_SRC(NUM_EX_SRC)) i_ex_select (
        .consumer_valid_i (ex_valid_i),
        .mem_hit_i        (ex_mem_hit),
        .wb_hit_i         (ex_wb_hit),
        .sel_o            (live_sel)
    );

    fwd_read_bypass #(.REG_ADDR_W(REG_ADDR_W), .NUM_PORTS(NUM_RD_PORTS)) i_read_bypass (
        .addr_i   (rd_addr_i),
        .wb_hit_i (rd_wb_hit),
        .sel_o    (rd_sel_o)
    );

    // Purpose: store-data bypass and load-use detection from the hit vectors.
    always_comb begin
        live_store  = mem_valid_i && st_wb_hit[0];
        load_hazard = ex_valid_i && mem_load_i && (|ex_mem_hit);
    end

    // Purpose: remember the last decision taken while the pipeline advanced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_sel   <= '0;
            held_store <= 1'b0;
        end else if (!pipe_hold_i) begin
            held_sel   <= live_sel;
            held_store <= live_store;
        end
    end

    // Purpose: present held decisions during a hold, live ones otherwise.
    always_comb begin
        ex_opd_sel_o    = pipe_hold_i ? held_sel : live_sel;
        mem_store_fwd_o = pipe_hold_i ? held_store : live_store;
        load_stall_o    = load_hazard && !pipe_hold_i;
    end

    // ---------------- assertions ----------------
    for (genvar k = 0; k < NUM_EX_SRC; k++) begin : g_chk
        // A zero source never takes a bypassed value (R6).
        assert_zero_src_no_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!pipe_hold_i && ex_src_i[k] == '0) |-> ex_opd_sel_o[k] == 2'd0);
        // Memory-stage match beats write-back match (R3).
        assert_mem_beats_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!pipe_hold_i && ex_valid_i && mem_valid_i && mem_we_i && mem_rd_i != '0
             && mem_rd_i == ex_src_i[k]) |-> ex_opd_sel_o[k] == 2'd1);
    end

    // No producer alive means no bypass anywhere (R7).
    assert_dead_producers_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_hold_i && !mem_valid_i && !wb_valid_i) |-> (ex_opd_sel_o == '0 && !mem_store_fwd_o));

    // A stall request needs a live load and a live consumer (R9).
    assert_stall_needs_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_stall_o |-> (mem_load_i && mem_valid_i && mem_we_i && ex_valid_i));

    // Selects do not move across consecutive held cycles (R10).
    assert_hold_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_hold_i && $past(pipe_hold_i) && $past(rst_n)) |->
        ($stable(ex_opd_sel_o) && $stable(mem_store_fwd_o)));

    // Reads of x0 always go to the zero constant (R6).
    assert_x0_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i[0] == '0) |-> rd_sel_o[0] == 2'd2);

endmodule

// File: tb/test_fwd_hazard_unit.sv
// Bench: sweeps all index combinations of a three-bit register space and
// runs directed hold and reset sequences. Expected values are computed here.
module test_fwd_hazard_unit;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold = 1'b0;
    logic ex_valid = 1'b0;
    logic [1:0][AW-1:0] ex_src = '0;
    logic mem_valid = 1'b0, mem_we = 1'b0, mem_load = 1'b0;
    logic [AW-1:0] mem_rd = '0, mem_st = '0;
    logic wb_valid = 1'b0, wb_we = 1'b0;
    logic [AW-1:0] wb_rd = '0;
    logic [1:0][AW-1:0] rd_addr = '0;
    logic [1:0][1:0] ex_sel;
    logic store_fwd;
    logic [1:0][1:0] rd_sel;
    logic stall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fwd_hazard_unit #(.REG_ADDR_W(AW), .NUM_EX_SRC(2), .NUM_RD_PORTS(2)) i_fwd_hazard_unit (
        .clk(clk), .rst_n(rst_n), .pipe_hold_i(hold),
        .ex_valid_i(ex_valid), .ex_src_i(ex_src),
        .mem_valid_i(mem_valid), .mem_we_i(mem_we), .mem_load_i(mem_load),
        .mem_rd_i(mem_rd), .mem_store_src_i(mem_st),
        .wb_valid_i(wb_valid), .wb_we_i(wb_we), .wb_rd_i(wb_rd),
        .rd_addr_i(rd_addr),
        .ex_opd_sel_o(ex_sel), .mem_store_fwd_o(store_fwd),
        .rd_sel_o(rd_sel), .load_stall_o(stall)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (time %0t)", req, act, exp, $time);
        end
    endtask

    function automatic bit mem_hits(input logic [AW-1:0] s);
        return mem_valid && mem_we && mem_rd != 0 && mem_rd == s;
    endfunction
    function automatic bit wb_hits(input logic [AW-1:0] s);
        return wb_valid && wb_we && wb_rd != 0 && wb_rd == s;
    endfunction

    // Full expected-value check of the live (unheld) behaviour.
    task automatic check_live();
        for (int k = 0; k < 2; k++) begin
            int e;
            if (!ex_valid) e = 0;                   // R8
            else if (mem_hits(ex_src[k])) e = 1;     // R1, R3
            else if (wb_hits(ex_src[k])) e = 2;      // R2
            else e = 0;
            check(e == 1 ? "R1/R3 mem bypass" : (e == 2 ? "R2 wb bypass" : "R7/R8 regfile"),
                  int'(ex_sel[k]), e);
        end
        check("R4 store bypass", int'(store_fwd), int'(mem_valid && wb_hits(mem_st)));
        for (int p = 0; p < 2; p++) begin
            int e;
            if (rd_addr[p] == 0) e = 2;              // R6
            else if (wb_hits(rd_addr[p])) e = 1;     // R5
            else e = 0;
            check(e == 2 ? "R6 x0 read" : "R5 read transparency", int'(rd_sel[p]), e);
        end
        check("R9 load stall", int'(stall),
              int'(ex_valid && mem_load && (mem_hits(ex_src[0]) || mem_hits(ex_src[1]))));
    endtask

    initial begin
        // R11: reset with hold asserted and live hits present.
        hold = 1'b1; ex_valid = 1'b1; ex_src[0] = 3'd2; ex_src[1] = 3'd5;
        mem_valid = 1'b1; mem_we = 1'b1; mem_rd = 3'd2; mem_st = 3'd5;
        wb_valid = 1'b1; wb_we = 1'b1; wb_rd = 3'd5;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11 reset sel0", int'(ex_sel[0]), 0);
        check("R11 reset sel1", int'(ex_sel[1]), 0);
        check("R11 reset store", int'(store_fwd), 0);
        check("R10 stall masked in hold", int'(stall), 0);
        @(posedge clk); #1 rst_n = 1'b1; hold = 1'b0;

        // Sweep: pass 0 all producers alive, pass 1 scrambled flags.
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 4096; i++) begin
                int f;
                @(posedge clk); #1;
                ex_src[0] = i[2:0]; ex_src[1] = i[5:3];
                mem_rd = i[8:6];    wb_rd = i[11:9];
                mem_st = i[5:3] ^ i[2:0];
                rd_addr[0] = i[2:0]; rd_addr[1] = i[8:6];
                f = (pass == 0) ? (63 ^ ((i >> 3) & 16)) : ((i * 29 + (i >> 7)) & 63);
                ex_valid = f[0]; mem_valid = f[1]; mem_we = f[2];
                wb_valid = f[3]; mem_load = f[4]; wb_we = f[5];
                @(negedge clk);
                check_live();
            end
        end

        // R10: decide, then hold while inputs change underneath.
        @(posedge clk); #1;
        ex_valid = 1; ex_src[0] = 3'd3; ex_src[1] = 3'd5;
        mem_valid = 1; mem_we = 1; mem_load = 0; mem_rd = 3'd3; mem_st = 3'd5;
        wb_valid = 1; wb_we = 1; wb_rd = 3'd5;
        @(negedge clk);
        check_live();
        @(posedge clk); #1;
        hold = 1; ex_src[0] = 3'd4; ex_src[1] = 3'd0; mem_rd = 3'd4; mem_load = 1;
        wb_valid = 0; rd_addr[0] = 3'd0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R10 held sel0", int'(ex_sel[0]), 1);
            check("R10 held sel1", int'(ex_sel[1]), 2);
            check("R10 held store", int'(store_fwd), 1);
            check("R10 stall masked", int'(stall), 0);
            check("R6 x0 read during hold", int'(rd_sel[0]), 2);
            @(posedge clk); #1;
        end
        hold = 0;
        @(negedge clk);
        check("R9 stall after release", int'(stall), 1);
        check_live();
        done = 1'b1;
    end

    // Watchdog and end-of-run report.
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule